// File: doc/BRIEF.md
# Group-Three Logic Decoder and Execute Stage

This block takes 16-bit instruction words and handles the group whose top nybble is 3. In that group, bits [15:7] form the main operation and the low seven bits [6:0] form an extension field. Bit 7 chooses between two families that share the same upper bits. The block executes the bitwise operations of the group on the 16-bit middle word of a 40-bit accumulator. The other operand is either the high half of an auxiliary register or the middle word of the other accumulator. The block writes the updated destination accumulator and a set of status flags one cycle after the strobe.

Variable-shift instructions of the group are decoded here but not executed. The block forwards a shift request, the shift kind, the destination and the selected shift-amount word to a separate shift unit. For every strobed word, of any group, the block also presents the extension field in the form the extension decoder expects. A strobed word outside group three raises an illegal indication and changes no state.

Top module: `g3_exec`

## Requirements
- R1: For a strobed group-three word, `op_code` one cycle later encodes the operation as follows. With bit 7 = 0, the key bits [11:10] decode as: 00 is XOR with aux (1), 01 is AND with aux (2), 10 is OR with aux (3). Key 11 decodes as AND with the other accumulator (4) when bit 9 = 0, and as OR with the other accumulator (5) when bit 9 = 1. With bit 7 = 1, key 00 decodes as XOR with the other accumulator (6) when bit 9 = 0, and as invert (7) when bit 9 = 1. Key 01 is logical shift by aux (8) and key 10 is arithmetic shift by aux (9). Key 11 decodes as logical shift by the other accumulator (10) when bit 9 = 0, and as arithmetic shift by the other accumulator (11) when bit 9 = 1. The value 15 marks an illegal word and 0 marks no strobe.
- R2: All outputs are registered with a latency of exactly one cycle. `wr_en`, `illegal` and `shift_req` are one-cycle pulses, and at most one of them is high in any cycle.
- R3: In the aux-register forms (codes 1 to 3), bit 9 selects `aux1_hi` (1) or `aux0_hi` (0), and bit 8 selects the destination `acc1_in` (1) or `acc0_in` (0). The destination middle word is combined with the selected aux word.
- R4: In the accumulator forms (codes 4 to 6), the source is the middle word [31:16] of the accumulator that is not the destination.
- R5: A logic operation changes only bits [31:16] of the destination. Bits [39:32] and [15:0] of `wr_acc` equal those of the input destination accumulator.
- R6: Invert (code 7) replaces the destination middle word with its bitwise complement.
- R7: On each write, `flag_zero` is set when all 40 bits of the result are zero, `flag_sign` equals result bit 39, and `flag_midzero` is set when result bits [31:16] are zero.
- R8: The flags hold their value in every cycle without a write, including cycles with shift or illegal words. They reset to zero.
- R9: For shift codes 8 to 11, `shift_req` pulses and `shift_arith` is 1 for codes 9 and 11. `shift_dest` is bit 8. `shift_amount` is the selected aux high half (codes 8 and 9) or the other accumulator's middle word (codes 10 and 11). No accumulator write occurs.
- R10: For a word with top nybble 3, `ext_field` is bits [6:0] with a zero in bit 7. For a top nybble of 4 or more, it is bits [7:0]. In both cases `ext_present` is 1. For top nybbles 0 to 2, both outputs are 0.
- R11: A strobed word whose top nybble is not 3 pulses `illegal`, reports code 15, and causes neither a write nor a shift request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| acc0_in | input | 40 | Accumulator 0 |
| acc1_in | input | 40 | Accumulator 1 |
| aux0_hi | input | 16 | High half of auxiliary register 0 |
| aux1_hi | input | 16 | High half of auxiliary register 1 |
| wr_en | output | 1 | Destination write pulse |
| wr_dest | output | 1 | Destination accumulator index |
| wr_acc | output | 40 | Updated destination accumulator |
| flag_zero | output | 1 | Result is all zero |
| flag_sign | output | 1 | Result bit 39 |
| flag_midzero | output | 1 | Result middle word is zero |
| op_code | output | 4 | Decoded operation code |
| ext_present | output | 1 | Word carries an extension |
| ext_field | output | 8 | Extension field for the extension decoder |
| illegal | output | 1 | Word outside this group |
| shift_req | output | 1 | Request to the shift unit |
| shift_arith | output | 1 | Shift is arithmetic |
| shift_dest | output | 1 | Shift destination accumulator |
| shift_amount | output | 16 | Selected shift-amount word |

## Verification
Each strobe gives a single-cycle result. A wrong decode or a wrong operand select therefore shows at the ports in the very next cycle, as a wrong `op_code`, a wrong `wr_acc` or a pulse on the wrong strobe. Flags are the only state that outlives one instruction. A flag register that updates when it should hold is visible only after a later non-write instruction, so the tests compare the flags across shift, illegal and idle cycles. The extension field's top bit is checked on group-three words whose low byte has bit 7 set, because that is the only case where forcing the bit changes the value.

// File: rtl/g3_pkg.sv
package g3_pkg;

   localparam int unsigned G3_OP_W = 4;

   typedef enum logic [G3_OP_W-1:0] {
      OP_NONE    = 4'd0,
      OP_XOR_AUX = 4'd1,
      OP_AND_AUX = 4'd2,
      OP_OR_AUX  = 4'd3,
      OP_AND_ACC = 4'd4,
      OP_OR_ACC  = 4'd5,
      OP_XOR_ACC = 4'd6,
      OP_INV     = 4'd7,
      OP_LSH_AUX = 4'd8,
      OP_ASH_AUX = 4'd9,
      OP_LSH_ACC = 4'd10,
      OP_ASH_ACC = 4'd11,
      OP_ILL     = 4'd15
   } g3_op_e;

   typedef struct packed {
      g3_op_e op;
      logic   in_group;
      logic   is_logic;
      logic   is_shift;
      logic   arith;
      logic   dest;
      logic   src_aux;
      logic   aux_sel;
   } g3_dec_t;

endpackage

// File: rtl/g3_decode.sv
module g3_decode
   import g3_pkg::*;
#(
   parameter int unsigned INSTR_W   = 16,
   parameter int unsigned NYB_W     = 4,
   parameter int unsigned GROUP_NYB = 3
) (
   input  logic [INSTR_W-1:0] instr,
   output g3_dec_t            dec
);

   if (INSTR_W != 16) begin : g_chk_w
      $error("g3_decode: INSTR_W must be 16");
   end
   if (GROUP_NYB >= (1 << NYB_W)) begin : g_chk_nyb
      $error("g3_decode: GROUP_NYB does not fit in NYB_W");
   end

   localparam int unsigned FAM_BIT  = 7;
   localparam int unsigned SRC_BIT  = 9;
   localparam int unsigned DST_BIT  = 8;
   localparam int unsigned KEY_LSB  = 10;

   logic [NYB_W-1:0] nyb;
   logic [1:0]       key;
   logic             fam;
   logic             b_src;

   assign nyb   = instr[INSTR_W-1 -: NYB_W];
   assign key   = instr[KEY_LSB +: 2];
   assign fam   = instr[FAM_BIT];
   assign b_src = instr[SRC_BIT];

   always_comb begin
      dec          = '0;
      dec.op       = OP_NONE;
      dec.dest     = instr[DST_BIT];
      dec.aux_sel  = b_src;
      if (nyb != NYB_W'(GROUP_NYB)) begin
         dec.op = OP_ILL;
      end else begin
         dec.in_group = 1'b1;
         unique case ({fam, key})
            3'b0_00: begin dec.op = OP_XOR_AUX; dec.is_logic = 1'b1; dec.src_aux = 1'b1; end
            3'b0_01: begin dec.op = OP_AND_AUX; dec.is_logic = 1'b1; dec.src_aux = 1'b1; end
            3'b0_10: begin dec.op = OP_OR_AUX;  dec.is_logic = 1'b1; dec.src_aux = 1'b1; end
            3'b0_11: begin
               dec.op       = b_src ? OP_OR_ACC : OP_AND_ACC;
               dec.is_logic = 1'b1;
            end
            3'b1_00: begin
               dec.op       = b_src ? OP_INV : OP_XOR_ACC;
               dec.is_logic = 1'b1;
            end
            3'b1_01: begin dec.op = OP_LSH_AUX; dec.is_shift = 1'b1; dec.src_aux = 1'b1; end
            3'b1_10: begin
               dec.op       = OP_ASH_AUX;
               dec.is_shift = 1'b1;
               dec.src_aux  = 1'b1;
               dec.arith    = 1'b1;
            end
            default: begin
               dec.op       = b_src ? OP_ASH_ACC : OP_LSH_ACC;
               dec.is_shift = 1'b1;
               dec.arith    = b_src;
            end
         endcase
      end
   end

endmodule

// File: rtl/g3_ext_split.sv
module g3_ext_split #(
   parameter int unsigned INSTR_W   = 16,
   parameter int unsigned NYB_W     = 4,
   parameter int unsigned GROUP_NYB = 3,
   parameter int unsigned NOEXT_MAX = 2,
   parameter int unsigned EXT_W     = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               present,
   output logic [EXT_W-1:0]   field
);

   if (NOEXT_MAX >= GROUP_NYB) begin : g_chk_order
      $error("g3_ext_split: NOEXT_MAX must be below GROUP_NYB");
   end
   if (EXT_W + NYB_W > INSTR_W) begin : g_chk_ext
      $error("g3_ext_split: extension overlaps the nybble");
   end

   logic [NYB_W-1:0] nyb;
   assign nyb = instr[INSTR_W-1 -: NYB_W];

   always_comb begin
      present = 1'b0;
      field   = '0;
      if (nyb > NYB_W'(NOEXT_MAX)) begin
         present = 1'b1;
         field   = instr[EXT_W-1:0];
         if (nyb == NYB_W'(GROUP_NYB)) begin
            field[EXT_W-1] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/g3_logic.sv
module g3_logic
   import g3_pkg::*;
#(
   parameter int unsigned ACC_W   = 40,
   parameter int unsigned MID_LSB = 16,
   parameter int unsigned MID_W   = 16
) (
   input  g3_op_e           op,
   input  logic [ACC_W-1:0] dst_acc,
   input  logic [MID_W-1:0] src_word,
   output logic [ACC_W-1:0] new_acc
);

   if (MID_LSB + MID_W > ACC_W) begin : g_chk_fit
      $error("g3_logic: middle word exceeds accumulator");
   end

   logic [MID_W-1:0] mid_in;
   logic [MID_W-1:0] mid_out;

   assign mid_in = dst_acc[MID_LSB +: MID_W];

   always_comb begin
      unique case (op)
         OP_XOR_AUX, OP_XOR_ACC: mid_out = mid_in ^ src_word;
         OP_AND_AUX, OP_AND_ACC: mid_out = mid_in & src_word;
         OP_OR_AUX,  OP_OR_ACC:  mid_out = mid_in | src_word;
         OP_INV:                 mid_out = ~mid_in;
         default:                mid_out = mid_in;
      endcase
   end

   always_comb begin
      new_acc                     = dst_acc;
      new_acc[MID_LSB +: MID_W]   = mid_out;
   end

endmodule

// File: rtl/g3_flags.sv
module g3_flags #(
   parameter int unsigned ACC_W      = 40,
   parameter int unsigned MID_LSB    = 16,
   parameter int unsigned MID_W      = 16,
   parameter bit          MIDZERO_EN = 1'b1
) (
   input  logic [ACC_W-1:0] value,
   output logic             zero,
   output logic             sign,
   output logic             midzero
);

   assign zero = (value == '0);
   assign sign = value[ACC_W-1];

   if (MIDZERO_EN) begin : g_midzero
      assign midzero = (value[MID_LSB +: MID_W] == '0);
   end else begin : g_no_midzero
      assign midzero = 1'b0;
   end

endmodule

// File: rtl/g3_exec.sv
module g3_exec
   import g3_pkg::*;
#(
   parameter int unsigned ACC_W      = 40,
   parameter int unsigned MID_LSB    = 16,
   parameter int unsigned MID_W      = 16,
   parameter int unsigned INSTR_W    = 16,
   parameter int unsigned EXT_W      = 8,
   parameter bit          MIDZERO_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ACC_W-1:0]   acc0_in,
   input  logic [ACC_W-1:0]   acc1_in,
   input  logic [MID_W-1:0]   aux0_hi,
   input  logic [MID_W-1:0]   aux1_hi,
   output logic               wr_en,
   output logic               wr_dest,
   output logic [ACC_W-1:0]   wr_acc,
   output logic               flag_zero,
   output logic               flag_sign,
   output logic               flag_midzero,
   output logic [G3_OP_W-1:0] op_code,
   output logic               ext_present,
   output logic [EXT_W-1:0]   ext_field,
   output logic               illegal,
   output logic               shift_req,
   output logic               shift_arith,
   output logic               shift_dest,
   output logic [MID_W-1:0]   shift_amount
);

   if (MID_LSB + MID_W > ACC_W) begin : g_chk_fit
      $error("g3_exec: middle word exceeds accumulator");
   end
   if (MID_W != INSTR_W) begin : g_chk_mid
      $error("g3_exec: middle word must match the data word width");
   end

   g3_dec_t            dec;
   logic               ext_p_d;
   logic [EXT_W-1:0]   ext_f_d;
   logic [ACC_W-1:0]   dst_acc;
   logic [MID_W-1:0]   other_mid;
   logic [MID_W-1:0]   aux_word;
   logic [MID_W-1:0]   src_word;
   logic [ACC_W-1:0]   new_acc;
   logic               z_d, s_d, m_d;

   g3_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   g3_ext_split #(.INSTR_W(INSTR_W), .EXT_W(EXT_W)) u_ext (
      .instr   (instr),
      .present (ext_p_d),
      .field   (ext_f_d)
   );

   assign dst_acc   = dec.dest ? acc1_in : acc0_in;
   assign other_mid = dec.dest ? acc0_in[MID_LSB +: MID_W] : acc1_in[MID_LSB +: MID_W];
   assign aux_word  = dec.aux_sel ? aux1_hi : aux0_hi;
   assign src_word  = dec.src_aux ? aux_word : other_mid;

   g3_logic #(.ACC_W(ACC_W), .MID_LSB(MID_LSB), .MID_W(MID_W)) u_logic (
      .op       (dec.op),
      .dst_acc  (dst_acc),
      .src_word (src_word),
      .new_acc  (new_acc)
   );

   g3_flags #(.ACC_W(ACC_W), .MID_LSB(MID_LSB), .MID_W(MID_W),
              .MIDZERO_EN(MIDZERO_EN)) u_flags (
      .value   (new_acc),
      .zero    (z_d),
      .sign    (s_d),
      .midzero (m_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en        <= 1'b0;
         wr_dest      <= 1'b0;
         wr_acc       <= '0;
         flag_zero    <= 1'b0;
         flag_sign    <= 1'b0;
         flag_midzero <= 1'b0;
         op_code      <= OP_NONE;
         ext_present  <= 1'b0;
         ext_field    <= '0;
         illegal      <= 1'b0;
         shift_req    <= 1'b0;
         shift_arith  <= 1'b0;
         shift_dest   <= 1'b0;
         shift_amount <= '0;
      end else begin
         wr_en       <= 1'b0;
         illegal     <= 1'b0;
         shift_req   <= 1'b0;
         op_code     <= OP_NONE;
         ext_present <= 1'b0;
         ext_field   <= '0;
         if (instr_valid) begin
            op_code     <= dec.op;
            ext_present <= ext_p_d;
            ext_field   <= ext_f_d;
            if (!dec.in_group) begin
               illegal <= 1'b1;
            end else if (dec.is_logic) begin
               wr_en        <= 1'b1;
               wr_dest      <= dec.dest;
               wr_acc       <= new_acc;
               flag_zero    <= z_d;
               flag_sign    <= s_d;
               flag_midzero <= m_d;
            end else if (dec.is_shift) begin
               shift_req    <= 1'b1;
               shift_arith  <= dec.arith;
               shift_dest   <= dec.dest;
               shift_amount <= src_word;
            end
         end
      end
   end

endmodule

// File: rtl/g3_exec_chk.sv
module g3_exec_chk #(
   parameter int unsigned ACC_W   = 40,
   parameter int unsigned MID_LSB = 16,
   parameter int unsigned MID_W   = 16,
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned EXT_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               instr_valid,
   input logic [INSTR_W-1:0] instr,
   input logic [ACC_W-1:0]   acc0_in,
   input logic [ACC_W-1:0]   acc1_in,
   input logic               wr_en,
   input logic [ACC_W-1:0]   wr_acc,
   input logic               flag_zero,
   input logic               flag_sign,
   input logic               flag_midzero,
   input logic [EXT_W-1:0]   ext_field,
   input logic               illegal,
   input logic               shift_req
);

   localparam logic [ACC_W-1:0] MID_MASK = ((ACC_W'(1) << MID_W) - ACC_W'(1)) << MID_LSB;

   logic [ACC_W-1:0] sel_acc;
   logic             grp3_strobe;
   assign sel_acc     = instr[8] ? acc1_in : acc0_in;
   assign grp3_strobe = instr_valid && (instr[INSTR_W-1 -: 4] == 4'd3);

   a_r2_write_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(instr_valid));

   a_r2_one_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, illegal, shift_req}));

   a_r5_outside_mid_kept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (((wr_acc ^ $past(sel_acc)) & ~MID_MASK) == '0));

   a_r7_sign_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (flag_sign == wr_acc[ACC_W-1]));

   a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> $stable({flag_zero, flag_sign, flag_midzero}));

   a_r10_ext_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp3_strobe) |-> !ext_field[EXT_W-1]);

   a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!wr_en && !shift_req && $past(instr_valid)));

endmodule

bind g3_exec g3_exec_chk #(
   .ACC_W(ACC_W), .MID_LSB(MID_LSB), .MID_W(MID_W), .INSTR_W(INSTR_W), .EXT_W(EXT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_valid  (instr_valid),
   .instr        (instr),
   .acc0_in      (acc0_in),
   .acc1_in      (acc1_in),
   .wr_en        (wr_en),
   .wr_acc       (wr_acc),
   .flag_zero    (flag_zero),
   .flag_sign    (flag_sign),
   .flag_midzero (flag_midzero),
   .ext_field    (ext_field),
   .illegal      (illegal),
   .shift_req    (shift_req)
);

// File: tb/sim_g3_exec.sv
`timescale 1ns/1ps
module sim_g3_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [39:0] acc0_in = '0;
   logic [39:0] acc1_in = '0;
   logic [15:0] aux0_hi = '0;
   logic [15:0] aux1_hi = '0;
   logic        wr_en, wr_dest, flag_zero, flag_sign, flag_midzero;
   logic [39:0] wr_acc;
   logic [3:0]  op_code;
   logic        ext_present, illegal, shift_req, shift_arith, shift_dest;
   logic [7:0]  ext_field;
   logic [15:0] shift_amount;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   g3_exec u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .acc0_in(acc0_in), .acc1_in(acc1_in), .aux0_hi(aux0_hi), .aux1_hi(aux1_hi),
      .wr_en(wr_en), .wr_dest(wr_dest), .wr_acc(wr_acc),
      .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_midzero(flag_midzero),
      .op_code(op_code), .ext_present(ext_present), .ext_field(ext_field),
      .illegal(illegal), .shift_req(shift_req), .shift_arith(shift_arith),
      .shift_dest(shift_dest), .shift_amount(shift_amount)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected operation code from the R1 encoding table
   function automatic int exp_op(input logic [15:0] w);
      if (w[15:12] != 4'd3) return 15;
      case ({w[7], w[11:10]})
         3'b000: return 1;
         3'b001: return 2;
         3'b010: return 3;
         3'b011: return w[9] ? 5 : 4;
         3'b100: return w[9] ? 7 : 6;
         3'b101: return 8;
         3'b110: return 9;
         default: return w[9] ? 11 : 10;
      endcase
   endfunction

   // Strobe one word; on return the registered outputs for it are visible
   task automatic issue(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R2 reset wr_en", wr_en, 0);
      chk("R8 reset flags", {flag_zero, flag_sign, flag_midzero}, 0);
      chk("R1 reset op", op_code, 0);
      chk("R11 reset illegal", illegal, 0);
   endtask

   task automatic t_decode_all;
      for (int f = 0; f < 2; f++)
         for (int k = 0; k < 4; k++)
            for (int b = 0; b < 2; b++) begin
               logic [15:0] w;
               w = {4'h3, 2'(k), 1'(b), 1'b0, 1'(f), 7'h15};
               issue(w);
               chk("R1 op decode", op_code, 64'(exp_op(w)));
            end
   endtask

   task automatic t_aux_logic;
      acc0_in = 40'h11_F0F0_2222;
      acc1_in = 40'h9A_0FF0_BEEF;
      aux0_hi = 16'h3C3C;
      aux1_hi = 16'hAAAA;
      issue(16'h3300);   // XOR aux1 into acc1
      chk("R3 xor aux1->acc1 data", wr_acc, 40'h9A_A55A_BEEF);
      chk("R3 xor dest", wr_dest, 1);
      chk("R3 xor we", wr_en, 1);
      issue(16'h3400);   // AND aux0 into acc0
      chk("R3 and aux0->acc0", wr_acc, 40'h11_3030_2222);
      chk("R5 and dest", wr_dest, 0);
      issue(16'h3A00);   // OR aux1 into acc0
      chk("R3 or aux1->acc0", wr_acc, 40'h11_FAFA_2222);
   endtask

   task automatic t_acc_logic;
      acc0_in = 40'h00_1234_0001;
      acc1_in = 40'hFF_FF00_8000;
      issue(16'h3D00);   // AND acc0.mid into acc1
      chk("R4 and other acc", wr_acc, 40'hFF_1200_8000);
      issue(16'h3E00);   // OR acc1.mid into acc0
      chk("R4 or other acc", wr_acc, 40'h00_FF34_0001);
      issue(16'h3080);   // XOR acc1.mid into acc0
      chk("R4 xor other acc", wr_acc, 40'h00_ED34_0001);
   endtask

   task automatic t_invert;
      acc0_in = 40'h5A_0F0F_7777;
      acc1_in = 40'h80_0000_0000;
      issue(16'h3280);
      chk("R6 invert acc0", wr_acc, 40'h5A_F0F0_7777);
      issue(16'h3380);
      chk("R6 invert acc1", wr_acc, 40'h80_FFFF_0000);
      chk("R7 sign set", flag_sign, 1);
      chk("R7 nonzero", flag_zero, 0);
   endtask

   task automatic t_flags;
      acc0_in = 40'h00_4321_0000;
      acc1_in = 40'hC3_4321_0000;
      issue(16'h3080);   // acc0.mid ^= acc1.mid -> all zero
      chk("R7 zero flag", {flag_zero, flag_sign, flag_midzero}, 3'b101);
      issue(16'h3180);   // acc1.mid ^= acc0.mid -> mid zero, high nonzero
      chk("R7 midzero only", {flag_zero, flag_sign, flag_midzero}, 3'b011);
      chk("R5 high kept", wr_acc, 40'hC3_0000_0000);
   endtask

   task automatic t_flag_hold;
      acc0_in = 40'h00_0000_0000;
      acc1_in = 40'h00_0001_0000;
      issue(16'h3080);   // result acc0 mid 0001 -> flags 000
      chk("R7 flags clear", {flag_zero, flag_sign, flag_midzero}, 3'b000);
      acc0_in = 40'h0;
      acc1_in = 40'h0;
      issue(16'h3C80);   // shift, no write
      chk("R8 hold on shift", {flag_zero, flag_sign, flag_midzero}, 3'b000);
      issue(16'h4000);   // illegal
      chk("R8 hold on illegal", {flag_zero, flag_sign, flag_midzero}, 3'b000);
      @(negedge clk);
      chk("R8 hold idle", {flag_zero, flag_sign, flag_midzero}, 3'b000);
   endtask

   task automatic t_shift;
      acc0_in = 40'h00_BEEF_0000;
      acc1_in = 40'h00_1357_0000;
      aux0_hi = 16'h0041;
      aux1_hi = 16'h0007;
      issue(16'h3780);   // logical by aux1, dest 1
      chk("R9 req", {shift_req, wr_en}, 2'b10);
      chk("R9 lsh aux", {shift_arith, shift_dest, shift_amount}, {2'b01, 16'h0007});
      issue(16'h3880);   // arithmetic by aux0, dest 0
      chk("R9 ash aux", {shift_arith, shift_dest, shift_amount}, {2'b10, 16'h0041});
      issue(16'h3D80);   // logical by acc0.mid, dest 1
      chk("R9 lsh acc", {shift_arith, shift_dest, shift_amount}, {2'b01, 16'hBEEF});
      issue(16'h3E80);   // arithmetic by acc1.mid, dest 0
      chk("R9 ash acc", {shift_arith, shift_dest, shift_amount}, {2'b10, 16'h1357});
   endtask

   task automatic t_ext;
      issue(16'h30FF);
      chk("R10 group3 ext", {ext_present, ext_field}, {1'b1, 8'h7F});
      issue(16'h5AA5);
      chk("R10 high group ext", {ext_present, ext_field}, {1'b1, 8'hA5});
      issue(16'h12FF);
      chk("R10 no ext", {ext_present, ext_field}, {1'b0, 8'h00});
   endtask

   task automatic t_illegal;
      issue(16'h9380);
      chk("R11 illegal pulse", {illegal, wr_en, shift_req}, 3'b100);
      chk("R11 code", op_code, 15);
   endtask

   task automatic t_latency;
      issue(16'h3300);
      chk("R2 write pulse", wr_en, 1);
      @(negedge clk);
      chk("R2 pulse ends", {wr_en, illegal, shift_req}, 0);
      chk("R2 op idle", op_code, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode_all();
      t_aux_logic();
      t_acc_logic();
      t_invert();
      t_flags();
      t_flag_hold();
      t_shift();
      t_ext();
      t_illegal();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule